// File: doc/BRIEF.md
# Transmit Enable Ramp Sequencer

This block raises three transmit-enable strobes one after another when a radio transmitter is switched on. When the transmit request goes high, the first strobe rises at once. The second strobe follows after a first programmable gap, and the third follows after a second programmable gap. The first strobe is meant to drive the transmitter's command pin and the second its power-enable pin. The third strobe marks the end of the ramp, and a ready flag rises with it.

Both gaps come from one configuration byte that holds two 4-bit fields. Each gap is counted in steps of a fixed number of input clocks. A select bit doubles that step length, so one step is 20 or 40 clocks. With a 20 MHz clock and the short step, one step is 1 µs. When the request is removed, every strobe falls on the next edge and the sequencer goes back to idle.

Top module: `tx_ramp_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all of `t1_o`, `t2_o`, `t3_o` and `ready_o` are 0 after that edge, and the sequencer is idle.
- R2: In idle, a clock edge that sees `tx_req` high sets `t1_o` at that edge, while `t2_o` and `t3_o` stay 0.
- R3: The first gap G1 is `gap_cfg[7:4]` and the second gap G2 is `gap_cfg[3:0]`. `t2_o` rises D(G1) cycles after `t1_o` rises, and `t3_o` rises D(G2) cycles after `t2_o` rises.
- R4: For a nonzero gap G, D(G) = G × S cycles. S is 20 when `step_long` is 0 and 40 when it is 1.
- R5: A gap field of 0 gives D = 1: the next strobe rises on the clock edge after the previous one.
- R6: `ready_o` rises on the same edge as `t3_o`. Both stay high for as long as `tx_req` stays high.
- R7: A clock edge that sees `tx_req` low, in any phase, leaves all three strobes and `ready_o` at 0 after it and returns the sequencer to idle. No new sequence starts while `tx_req` stays low.
- R8: `gap_cfg` and `step_long` are captured at the edge that starts a sequence. Changes to them before the sequence completes have no effect on its timing.
- R9: The strobes only build up: `t2_o` is high only while `t1_o` is high, and `t3_o` only while `t2_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Transmit request level |
| gap_cfg | input | 8 | Gap fields: [7:4] first gap, [3:0] second gap |
| step_long | input | 1 | Step length select: 0 gives 20 clocks, 1 gives 40 clocks |
| t1_o | output | 1 | First strobe (transmit command) |
| t2_o | output | 1 | Second strobe (power enable) |
| t3_o | output | 1 | Third strobe |
| ready_o | output | 1 | Ramp complete flag |

## Verification
Some properties are checked on every cycle by assertions:
- the strobes only build up, one level at a time;
- `ready_o` rises together with `t3_o`;
- dropping the request clears all outputs one edge later;
- a sequence starts only from a request the design has seen.

The bench scenarios show everything else. They measure the exact gap lengths for both step sizes and for zero fields, and they show that the configuration is captured when a sequence starts. They also cover a drop of the request in the middle of a ramp and a reset during a sequence.

// File: rtl/tx_ramp_seq_pkg.sv
// Package: shared state type and helpers for the transmit ramp sequencer.
// Assumes: consumers import it before declaring their ports.
package tx_ramp_seq_pkg;

    // Sequencer phase: idle, waiting gap 1, waiting gap 2, holding at full ramp.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_GAP1 = 2'd1,
        PH_GAP2 = 2'd2,
        PH_HOLD = 2'd3
    } ramp_phase_t;

    // Width of a counter that must reach the value n-1.
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tx_ramp_step_gen.sv
// Module: step tick generator.
// Counts input clocks and pulses tick once every BASE or 2*BASE cycles,
// depending on long_sel. A clear restarts the count, so the first tick
// comes a full step after the clear edge.
// Assumes: long_sel is held steady between clears.
module tx_ramp_step_gen #(
    parameter int BASE = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic long_sel,
    output logic tick
);
    import tx_ramp_seq_pkg::*;

    localparam int CW = cnt_width(2 * BASE);
    localparam logic [CW-1:0] LAST_SHORT = CW'(BASE - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(2 * BASE - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Pick the terminal count for the selected step length.
    always_comb begin
        last = long_sel ? LAST_LONG : LAST_SHORT;
    end

    assign tick = (cnt_q == last);

    // Advance the clock counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tx_ramp_gap_count.sv
// Module: gap step counter.
// Loads a gap length in steps and counts down on each step tick. done
// pulses on the tick that ends the last step.
// Assumes: a loaded value of zero is handled by the caller; done never fires then.
module tx_ramp_gap_count #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);
    logic [GAP_W-1:0] rem_q;

    assign done = tick && (rem_q == GAP_W'(1));

    // Hold the remaining step count of the gap in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (tick && (rem_q != '0)) begin
            rem_q <= rem_q - 1'b1;
        end
    end

endmodule

// File: rtl/tx_ramp_seq.sv
// Module: transmit enable ramp sequencer (top).
// Raises t1 when a request is seen in idle, then t2 after gap 1 and t3
// (with ready) after gap 2. Each gap is counted in steps of STEP_BASE or
// 2*STEP_BASE clocks. Dropping the request clears everything on the next
// edge. The gap fields and step select are captured when a sequence starts.
// Assumes: the request is a synchronous level; reset is synchronous, active low.
module tx_ramp_seq #(
    parameter int GAP_W     = 4,
    parameter int STEP_BASE = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_req,
    input  logic [2*GAP_W-1:0] gap_cfg,
    input  logic               step_long,
    output logic               t1_o,
    output logic               t2_o,
    output logic               t3_o,
    output logic               ready_o
);
    import tx_ramp_seq_pkg::*;

    ramp_phase_t      phase_q, phase_d;
    logic [GAP_W-1:0] g1_q, g2_q;
    logic             long_q;
    logic             t1_q, t2_q, t3_q, rdy_q;
    logic             start, adv1, adv2;
    logic             tick, gap_done;
    logic             gc_load, ps_clear;
    logic [GAP_W-1:0] gc_val;

    // Event decode: start, end of gap 1, end of gap 2.
    always_comb begin
        start = (phase_q == PH_IDLE) && tx_req;
        adv1  = (phase_q == PH_GAP1) && tx_req && ((g1_q == '0) || gap_done);
        adv2  = (phase_q == PH_GAP2) && tx_req && ((g2_q == '0) || gap_done);
    end

    // Counter control: restart the count at the start of each gap.
    always_comb begin
        gc_load  = start || adv1;
        ps_clear = gc_load;
        gc_val   = start ? gap_cfg[2*GAP_W-1:GAP_W] : g2_q;
    end

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        if (!tx_req) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_GAP1;
                PH_GAP1: if (adv1) phase_d = PH_GAP2;
                PH_GAP2: if (adv2) phase_d = PH_HOLD;
                PH_HOLD: phase_d = PH_HOLD;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Capture the gap fields and step select when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q   <= '0;
            g2_q   <= '0;
            long_q <= 1'b0;
        end else if (start) begin
            g1_q   <= gap_cfg[2*GAP_W-1:GAP_W];
            g2_q   <= gap_cfg[GAP_W-1:0];
            long_q <= step_long;
        end
    end

    // Strobe and ready registers: set on their events, cleared on drop.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_req) begin
            t1_q  <= 1'b0;
            t2_q  <= 1'b0;
            t3_q  <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            if (start) t1_q <= 1'b1;
            if (adv1)  t2_q <= 1'b1;
            if (adv2) begin
                t3_q  <= 1'b1;
                rdy_q <= 1'b1;
            end
        end
    end

    tx_ramp_step_gen #(
        .BASE(STEP_BASE)
    ) step_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ps_clear),
        .long_sel(long_q),
        .tick    (tick)
    );

    tx_ramp_gap_count #(
        .GAP_W(GAP_W)
    ) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gc_load),
        .load_val(gc_val),
        .tick    (tick),
        .done    (gap_done)
    );

    assign t1_o    = t1_q;
    assign t2_o    = t2_q;
    assign t3_o    = t3_q;
    assign ready_o = rdy_q;

endmodule

// File: rtl/tx_ramp_seq_chk.sv
// Module: assertion checker for the ramp sequencer, bound to the top.
// Assumes: sampled on the design clock; disabled while reset is low.
module tx_ramp_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_req,
    input logic t1_o,
    input logic t2_o,
    input logic t3_o,
    input logic ready_o
);
    AST_T2_NEEDS_T1: assert property (@(posedge clk) disable iff (!rst_n) t2_o |-> t1_o); // R9
    AST_T3_NEEDS_T2: assert property (@(posedge clk) disable iff (!rst_n) t3_o |-> t2_o); // R9
    AST_T2_NOT_WITH_T1: assert property (@(posedge clk) disable iff (!rst_n) $rose(t2_o) |-> $past(t1_o)); // R3
    AST_T3_NOT_WITH_T2: assert property (@(posedge clk) disable iff (!rst_n) $rose(t3_o) |-> $past(t2_o)); // R3
    AST_READY_WITH_T3: assert property (@(posedge clk) disable iff (!rst_n) $rose(t3_o) |-> ready_o); // R6
    AST_READY_IMPLIES_T3: assert property (@(posedge clk) disable iff (!rst_n) ready_o |-> t3_o); // R6
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) !tx_req |=> (!t1_o && !t2_o && !t3_o && !ready_o)); // R7
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(t1_o) |-> $past(tx_req)); // R2
endmodule

bind tx_ramp_seq tx_ramp_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_req (tx_req),
    .t1_o   (t1_o),
    .t2_o   (t2_o),
    .t3_o   (t3_o),
    .ready_o(ready_o)
);

// File: tb/tx_ramp_seq_tb.sv
// Bench for the ramp sequencer: a table of gap settings, then directed cases.
module tx_ramp_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 20;
    localparam int WATCHDOG = 150000;
    localparam int NVEC = 8;
    // Each vector is {G1, G2, step_long}.
    localparam logic [8:0] VECS [NVEC] = '{
        {4'd1,  4'd1,  1'b0},
        {4'd2,  4'd3,  1'b0},
        {4'd0,  4'd0,  1'b0},
        {4'd0,  4'd5,  1'b1},
        {4'd4,  4'd0,  1'b1},
        {4'd15, 4'd15, 1'b1},
        {4'd15, 4'd1,  1'b0},
        {4'd3,  4'd2,  1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req = 1'b0;
    logic [7:0] gap_cfg = 8'h00;
    logic step_long = 1'b0;
    logic t1_o, t2_o, t3_o, ready_o;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tx_ramp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .gap_cfg(gap_cfg),
        .step_long(step_long), .t1_o(t1_o), .t2_o(t2_o), .t3_o(t3_o),
        .ready_o(ready_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int exp_delay(input logic [3:0] g, input logic sel);
        return (g == 4'd0) ? 1 : int'(g) * BASE * (sel ? 2 : 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one sequence and measures the gaps. When mutate is set, the
    // configuration inputs are changed right after the start edge.
    task automatic run_seq(input logic [3:0] g1, input logic [3:0] g2,
                           input logic sel, input bit mutate);
        int n;
        gap_cfg = {g1, g2};
        step_long = sel;
        tx_req = 1'b1;
        @(negedge clk);
        check("R2 t1 after start", int'(t1_o), 1);
        check("R2 t2 low at start", int'(t2_o), 0);
        if (mutate) begin
            gap_cfg = ~{g1, g2};
            step_long = ~sel;
        end
        n = 0;
        while (!t2_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(mutate ? "R8 gap1 unchanged" : (g1 == 0 ? "R5 gap1 zero" : "R3 R4 gap1"),
              n, exp_delay(g1, sel));
        check("R9 t1 held with t2", int'(t1_o), 1);
        n = 0;
        while (!t3_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(mutate ? "R8 gap2 unchanged" : (g2 == 0 ? "R5 gap2 zero" : "R3 R4 gap2"),
              n, exp_delay(g2, sel));
        check("R6 ready with t3", int'(ready_o), 1);
        repeat (5) @(negedge clk);
        check("R6 ready held", int'(ready_o && t3_o), 1);
        tx_req = 1'b0;
        @(negedge clk);
        check("R7 drop clears", int'({t1_o, t2_o, t3_o, ready_o}), 0);
        gap_cfg = 8'h00;
        step_long = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset outputs low", int'({t1_o, t2_o, t3_o, ready_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_seq(VECS[i][8:5], VECS[i][4:1], VECS[i][0], 1'b0);
            @(negedge clk);
        end

        // R8: configuration changed during the sequence.
        run_seq(4'd2, 4'd1, 1'b0, 1'b1);

        // R7: no restart while the request stays low.
        repeat (5) @(negedge clk);
        check("R7 idle stays low", int'(t1_o), 0);

        // R7: drop in the middle of gap 1, then a fresh full sequence.
        gap_cfg = 8'h33;
        tx_req = 1'b1;
        repeat (10) @(negedge clk);
        tx_req = 1'b0;
        @(negedge clk);
        check("R7 mid-gap drop", int'({t1_o, t2_o, t3_o}), 0);
        repeat (70) @(negedge clk);
        check("R7 no late t2 after drop", int'(t2_o), 0);
        run_seq(4'd1, 4'd0, 1'b0, 1'b0);

        // R1: reset during a sequence.
        gap_cfg = 8'h00;
        tx_req = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 pre-reset t3 high", int'(t3_o), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-sequence", int'({t1_o, t2_o, t3_o, ready_o}), 0);
        tx_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        n = 0;
        tx_req = 1'b1;
        @(negedge clk);
        check("R2 start after reset", int'(t1_o), 1);
        tx_req = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule